// File: doc/BRIEF.md
# Masked-Page Translation Buffer

A small, fully associative address translation buffer. Each slot holds a per-slot page mask, a virtual page number, an address-space identifier, a global flag and a pair of physical frame halves. Each half carries its own 3-bit cacheability code, a dirty bit and a valid bit. A search compares the requested page number against every slot in parallel. Bits that are set in a slot's own mask are left out of that slot's compare, so one slot can cover a larger page.

A search request returns a hit flag, the winning slot index, a probe result and the slot's contents, all registered one cycle after the request. The probe result is the index on a hit and all ones (-1) on a miss. Software-style maintenance works through four more paths. The first writes a slot at an explicit index. The second is a flush that empties the table. The third is a free-running next-slot pointer with an advance strobe, which a refill engine can use as a round-robin victim choice. The fourth is a combinational read port that fetches any slot by index.

Top module: `mask_tlb`

## Requirements
- R1: A slot matches a search only when the requested VPN and the stored VPN are equal on every bit position that is clear in that slot's mask; positions set in the mask are ignored.
- R2: A matching slot qualifies only when its global flag is set or its stored ASID equals the requested ASID.
- R3: When several slots qualify, the one with the lowest index is reported.
- R4: One cycle after `lkp_valid_i`, `res_valid_o` pulses high with `res_hit_o`, `res_idx_o` and `res_probe_o`; `res_probe_o` equals the index on a hit and all ones (-1) on a miss.
- R5: A slot is occupied when either half-valid bit is set; a slot with both half-valid bits clear never qualifies.
- R6: Each frame half is reported as one word {pfn, c[2:0], d, v, g}: c at bits 5:3, d at bit 2, v at bit 1, the slot's global flag at bit 0, and the frame number from bit 6 upward.
- R7: A write with `wr_idx_i` >= SIZE changes no slot, and `wr_reject_o` is high for the cycle after it.
- R8: A write to an occupied slot replaces it completely, so the old VPN no longer hits there.
- R9: A flush clears every slot to zero and returns `next_idx_o` to 0; a flush wins over a write or an advance in the same cycle.
- R10: Each `adv_i` moves `next_idx_o` up by one, wrapping from SIZE-1 to 0.
- R11: The read port sets `rd_ok_o` and returns the slot's fields only for `rd_idx_i` < SIZE; otherwise `rd_ok_o` is low and all read fields are zero.
- R12: After reset all slots are empty, `next_idx_o` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Search request strobe |
| lkp_vpn_i | input | VPN_W | Requested virtual page number |
| lkp_asid_i | input | ASID_W | Requested address-space ID |
| res_valid_o | output | 1 | Search result valid pulse |
| res_hit_o | output | 1 | A qualifying slot was found |
| res_idx_o | output | IDX_W | Index of winning slot |
| res_probe_o | output | PTR_W | Index on hit, all ones on miss |
| res_mask_o | output | VPN_W | Mask of winning slot |
| res_asid_o | output | ASID_W | ASID of winning slot |
| res_half0_o | output | PFN_W+6 | Encoded even half of winning slot |
| res_half1_o | output | PFN_W+6 | Encoded odd half of winning slot |
| wr_en_i | input | 1 | Slot write strobe |
| wr_idx_i | input | PTR_W | Target slot; values >= SIZE rejected |
| wr_mask_i | input | VPN_W | Page mask to store |
| wr_vpn_i | input | VPN_W | VPN to store |
| wr_asid_i | input | ASID_W | ASID to store |
| wr_global_i | input | 1 | Global flag to store |
| wr_pfn0_i | input | PFN_W | Even half frame number |
| wr_c0_i | input | 3 | Even half cacheability code |
| wr_d0_i | input | 1 | Even half dirty |
| wr_v0_i | input | 1 | Even half valid |
| wr_pfn1_i | input | PFN_W | Odd half frame number |
| wr_c1_i | input | 3 | Odd half cacheability code |
| wr_d1_i | input | 1 | Odd half dirty |
| wr_v1_i | input | 1 | Odd half valid |
| wr_reject_o | output | 1 | Previous write was out of range |
| flush_i | input | 1 | Clear all slots and the pointer |
| adv_i | input | 1 | Advance the next-slot pointer |
| next_idx_o | output | IDX_W | Next-slot pointer |
| rd_idx_i | input | PTR_W | Read port index |
| rd_ok_o | output | 1 | Read index in range |
| rd_vpn_o | output | VPN_W | Read slot VPN |
| rd_mask_o | output | VPN_W | Read slot mask |
| rd_asid_o | output | ASID_W | Read slot ASID |
| rd_half0_o | output | PFN_W+6 | Read slot even half, encoded |
| rd_half1_o | output | PFN_W+6 | Read slot odd half, encoded |

## Verification
The bench builds the block with SIZE=6, a 12-bit VPN, a 4-bit ASID and a 10-bit frame number. Six is not a power of two, so the index field has spare codes 6 and 7 in its low bits. That puts writes just past the end of the table in reach, along with the wrap of the pointer at a non-binary boundary, which takes only a few strobes. With this small table, overlapping slots, cleared half-valid bits and replaced slots can all be placed on neighbouring indices. The priority order and the occupancy rule are then seen directly in the reported index.

// File: rtl/mask_tlb_pkg.sv
package mask_tlb_pkg;
  localparam int unsigned C_W    = 3;        // cacheability code width
  localparam int unsigned META_W = C_W + 3;  // c, d, v, g below the frame number
endpackage

// File: rtl/mtlb_entry.sv
module mtlb_entry
  import mask_tlb_pkg::*;
#(
  parameter int unsigned VPN_W  = 19,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [VPN_W-1:0]  w_mask_i,
  input  logic [VPN_W-1:0]  w_vpn_i,
  input  logic [ASID_W-1:0] w_asid_i,
  input  logic              w_g_i,
  input  logic [PFN_W-1:0]  w_pfn0_i,
  input  logic [C_W-1:0]    w_c0_i,
  input  logic              w_d0_i,
  input  logic              w_v0_i,
  input  logic [PFN_W-1:0]  w_pfn1_i,
  input  logic [C_W-1:0]    w_c1_i,
  input  logic              w_d1_i,
  input  logic              w_v1_i,
  input  logic [VPN_W-1:0]  q_vpn_i,
  input  logic [ASID_W-1:0] q_asid_i,
  output logic              match_o,
  output logic [VPN_W-1:0]  mask_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [ASID_W-1:0] asid_o,
  output logic [PFN_W+META_W-1:0] half0_o,
  output logic [PFN_W+META_W-1:0] half1_o
);
  logic [VPN_W-1:0]  mask_q, vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic              g_q;
  logic [PFN_W-1:0]  pfn0_q, pfn1_q;
  logic [C_W-1:0]    c0_q, c1_q;
  logic              d0_q, d1_q, v0_q, v1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0; vpn_q <= '0; asid_q <= '0; g_q <= 1'b0;
      pfn0_q <= '0; c0_q <= '0; d0_q <= 1'b0; v0_q <= 1'b0;
      pfn1_q <= '0; c1_q <= '0; d1_q <= 1'b0; v1_q <= 1'b0;
    end else if (clr_i) begin
      mask_q <= '0; vpn_q <= '0; asid_q <= '0; g_q <= 1'b0;
      pfn0_q <= '0; c0_q <= '0; d0_q <= 1'b0; v0_q <= 1'b0;
      pfn1_q <= '0; c1_q <= '0; d1_q <= 1'b0; v1_q <= 1'b0;
    end else if (we_i) begin
      mask_q <= w_mask_i; vpn_q <= w_vpn_i; asid_q <= w_asid_i; g_q <= w_g_i;
      pfn0_q <= w_pfn0_i; c0_q <= w_c0_i; d0_q <= w_d0_i; v0_q <= w_v0_i;
      pfn1_q <= w_pfn1_i; c1_q <= w_c1_i; d1_q <= w_d1_i; v1_q <= w_v1_i;
    end
  end

  logic occ, tag_eq, id_ok;
  assign occ     = v0_q | v1_q;
  assign tag_eq  = ((q_vpn_i ^ vpn_q) & ~mask_q) == '0;
  assign id_ok   = g_q | (q_asid_i == asid_q);
  assign match_o = occ & tag_eq & id_ok;

  assign mask_o  = mask_q;
  assign vpn_o   = vpn_q;
  assign asid_o  = asid_q;
  assign half0_o = {pfn0_q, c0_q, d0_q, v0_q, g_q};
  assign half1_o = {pfn1_q, c1_q, d1_q, v1_q, g_q};
endmodule

// File: rtl/mtlb_prio.sv
module mtlb_prio #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // scan downward so the lowest set index is the last one written
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mtlb_ptr.sv
module mtlb_ptr #(
  parameter int unsigned SIZE  = 16,
  parameter int unsigned IDX_W = $clog2(SIZE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SIZE - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (clr_i)   ptr_o <= '0;
    else if (adv_i)   ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/mask_tlb.sv
module mask_tlb
  import mask_tlb_pkg::*;
#(
  parameter int unsigned SIZE   = 16,
  parameter int unsigned VPN_W  = 19,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 24,
  localparam int unsigned IDX_W  = (SIZE > 1) ? $clog2(SIZE) : 1,
  localparam int unsigned PTR_W  = IDX_W + 1,
  localparam int unsigned HALF_W = PFN_W + META_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic [PTR_W-1:0]  res_probe_o,
  output logic [VPN_W-1:0]  res_mask_o,
  output logic [ASID_W-1:0] res_asid_o,
  output logic [HALF_W-1:0] res_half0_o,
  output logic [HALF_W-1:0] res_half1_o,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_mask_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PFN_W-1:0]  wr_pfn0_i,
  input  logic [C_W-1:0]    wr_c0_i,
  input  logic              wr_d0_i,
  input  logic              wr_v0_i,
  input  logic [PFN_W-1:0]  wr_pfn1_i,
  input  logic [C_W-1:0]    wr_c1_i,
  input  logic              wr_d1_i,
  input  logic              wr_v1_i,
  output logic              wr_reject_o,
  input  logic              flush_i,
  input  logic              adv_i,
  output logic [IDX_W-1:0]  next_idx_o,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic              rd_ok_o,
  output logic [VPN_W-1:0]  rd_vpn_o,
  output logic [VPN_W-1:0]  rd_mask_o,
  output logic [ASID_W-1:0] rd_asid_o,
  output logic [HALF_W-1:0] rd_half0_o,
  output logic [HALF_W-1:0] rd_half1_o
);
  localparam logic [PTR_W-1:0] SIZE_P = PTR_W'(SIZE);

  logic [SIZE-1:0]   hit_vec;
  logic [VPN_W-1:0]  e_mask  [SIZE];
  logic [VPN_W-1:0]  e_vpn   [SIZE];
  logic [ASID_W-1:0] e_asid  [SIZE];
  logic [HALF_W-1:0] e_half0 [SIZE];
  logic [HALF_W-1:0] e_half1 [SIZE];

  logic wr_in_range;
  assign wr_in_range = wr_idx_i < SIZE_P;

  for (genvar g = 0; g < SIZE; g++) begin : g_slot
    logic we;
    assign we = wr_en_i & wr_in_range & (wr_idx_i == PTR_W'(g));
    mtlb_entry #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) i_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (flush_i),
      .we_i     (we),
      .w_mask_i (wr_mask_i),
      .w_vpn_i  (wr_vpn_i),
      .w_asid_i (wr_asid_i),
      .w_g_i    (wr_global_i),
      .w_pfn0_i (wr_pfn0_i),
      .w_c0_i   (wr_c0_i),
      .w_d0_i   (wr_d0_i),
      .w_v0_i   (wr_v0_i),
      .w_pfn1_i (wr_pfn1_i),
      .w_c1_i   (wr_c1_i),
      .w_d1_i   (wr_d1_i),
      .w_v1_i   (wr_v1_i),
      .q_vpn_i  (lkp_vpn_i),
      .q_asid_i (lkp_asid_i),
      .match_o  (hit_vec[g]),
      .mask_o   (e_mask[g]),
      .vpn_o    (e_vpn[g]),
      .asid_o   (e_asid[g]),
      .half0_o  (e_half0[g]),
      .half1_o  (e_half1[g])
    );
  end

  logic             sel_found;
  logic [IDX_W-1:0] sel_idx;

  mtlb_prio #(.N(SIZE), .IDX_W(IDX_W)) i_prio (
    .req_i   (hit_vec),
    .found_o (sel_found),
    .idx_o   (sel_idx)
  );

  logic [VPN_W-1:0]  sel_mask;
  logic [ASID_W-1:0] sel_asid;
  logic [HALF_W-1:0] sel_half0, sel_half1;

  always_comb begin
    sel_mask = '0; sel_asid = '0; sel_half0 = '0; sel_half1 = '0;
    for (int i = 0; i < SIZE; i++) begin
      if (sel_found && sel_idx == IDX_W'(i)) begin
        sel_mask  = e_mask[i];
        sel_asid  = e_asid[i];
        sel_half0 = e_half0[i];
        sel_half1 = e_half1[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_idx_o   <= '0;
      res_probe_o <= '0;
      res_mask_o  <= '0;
      res_asid_o  <= '0;
      res_half0_o <= '0;
      res_half1_o <= '0;
    end else begin
      res_valid_o <= lkp_valid_i;
      if (lkp_valid_i) begin
        res_hit_o   <= sel_found;
        res_idx_o   <= sel_idx;
        res_probe_o <= sel_found ? {1'b0, sel_idx} : '1;
        res_mask_o  <= sel_mask;
        res_asid_o  <= sel_asid;
        res_half0_o <= sel_half0;
        res_half1_o <= sel_half1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_reject_o <= 1'b0;
    else         wr_reject_o <= wr_en_i & ~wr_in_range & ~flush_i;
  end

  mtlb_ptr #(.SIZE(SIZE), .IDX_W(IDX_W)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flush_i),
    .adv_i  (adv_i),
    .ptr_o  (next_idx_o)
  );

  assign rd_ok_o = rd_idx_i < SIZE_P;

  always_comb begin
    rd_vpn_o = '0; rd_mask_o = '0; rd_asid_o = '0; rd_half0_o = '0; rd_half1_o = '0;
    for (int i = 0; i < SIZE; i++) begin
      if (rd_idx_i == PTR_W'(i)) begin
        rd_vpn_o   = e_vpn[i];
        rd_mask_o  = e_mask[i];
        rd_asid_o  = e_asid[i];
        rd_half0_o = e_half0[i];
        rd_half1_o = e_half1[i];
      end
    end
  end
endmodule

// File: rtl/mask_tlb_chk.sv
module mask_tlb_chk #(
  parameter int unsigned SIZE  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned PTR_W = 5,
  parameter int unsigned HALF_W = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lkp_valid_i,
  input logic              res_valid_o,
  input logic              res_hit_o,
  input logic [IDX_W-1:0]  res_idx_o,
  input logic              wr_en_i,
  input logic [PTR_W-1:0]  wr_idx_i,
  input logic              wr_reject_o,
  input logic              flush_i,
  input logic              adv_i,
  input logic [IDX_W-1:0]  next_idx_o,
  input logic [PTR_W-1:0]  rd_idx_i,
  input logic              rd_ok_o,
  input logic [HALF_W-1:0] rd_half0_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SIZE - 1);

  a_r4_result_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> res_valid_o);

  a_r4_idx_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> (32'(res_idx_o) < SIZE));

  a_r7_reject_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i && (32'(wr_idx_i) >= SIZE)) |=> wr_reject_o);

  a_r7_no_false_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !wr_reject_o);

  a_r9_flush_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (next_idx_o == '0));

  a_r9_flush_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 lkp_valid_i |=> !res_hit_o);

  a_r10_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !flush_i && next_idx_o == LAST) |=> (next_idx_o == '0));

  a_r10_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !flush_i && next_idx_o != LAST) |=> (next_idx_o == $past(next_idx_o) + 1'b1));

  a_r10_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !flush_i) |=> $stable(next_idx_o));

  a_r11_rd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rd_idx_i) >= SIZE) |-> (!rd_ok_o && rd_half0_o == '0));
endmodule

bind mask_tlb mask_tlb_chk #(
  .SIZE(SIZE), .IDX_W(IDX_W), .PTR_W(PTR_W), .HALF_W(HALF_W)
) i_mask_tlb_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_valid_i (lkp_valid_i),
  .res_valid_o (res_valid_o),
  .res_hit_o   (res_hit_o),
  .res_idx_o   (res_idx_o),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_reject_o (wr_reject_o),
  .flush_i     (flush_i),
  .adv_i       (adv_i),
  .next_idx_o  (next_idx_o),
  .rd_idx_i    (rd_idx_i),
  .rd_ok_o     (rd_ok_o),
  .rd_half0_o  (rd_half0_o)
);

// File: tb/test_mask_tlb.sv
`timescale 1ns/1ps
module test_mask_tlb;
  localparam int SIZE = 6, VW = 12, AW = 4, PW = 10;
  localparam int IW = 3, PT = 4, HW = PW + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          lkp_valid = 0;
  logic [VW-1:0] lkp_vpn = '0;
  logic [AW-1:0] lkp_asid = '0;
  logic          res_valid, res_hit;
  logic [IW-1:0] res_idx;
  logic [PT-1:0] res_probe;
  logic [VW-1:0] res_mask;
  logic [AW-1:0] res_asid;
  logic [HW-1:0] res_h0, res_h1;
  logic          wr_en = 0;
  logic [PT-1:0] wr_idx = '0;
  logic [VW-1:0] wr_mask = '0, wr_vpn = '0;
  logic [AW-1:0] wr_asid = '0;
  logic          wr_g = 0;
  logic [PW-1:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic [2:0]    wr_c0 = '0, wr_c1 = '0;
  logic          wr_d0 = 0, wr_v0 = 0, wr_d1 = 0, wr_v1 = 0;
  logic          wr_reject;
  logic          flush = 0, adv = 0;
  logic [IW-1:0] next_idx;
  logic [PT-1:0] rd_idx = '0;
  logic          rd_ok;
  logic [VW-1:0] rd_vpn, rd_mask;
  logic [AW-1:0] rd_asid;
  logic [HW-1:0] rd_h0, rd_h1;

  int n_chk = 0, n_bad = 0;

  mask_tlb #(.SIZE(SIZE), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW)) i_mask_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vpn_i(lkp_vpn), .lkp_asid_i(lkp_asid),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_idx_o(res_idx),
    .res_probe_o(res_probe), .res_mask_o(res_mask), .res_asid_o(res_asid),
    .res_half0_o(res_h0), .res_half1_o(res_h1),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_mask_i(wr_mask), .wr_vpn_i(wr_vpn),
    .wr_asid_i(wr_asid), .wr_global_i(wr_g),
    .wr_pfn0_i(wr_pfn0), .wr_c0_i(wr_c0), .wr_d0_i(wr_d0), .wr_v0_i(wr_v0),
    .wr_pfn1_i(wr_pfn1), .wr_c1_i(wr_c1), .wr_d1_i(wr_d1), .wr_v1_i(wr_v1),
    .wr_reject_o(wr_reject), .flush_i(flush), .adv_i(adv), .next_idx_o(next_idx),
    .rd_idx_i(rd_idx), .rd_ok_o(rd_ok), .rd_vpn_o(rd_vpn), .rd_mask_o(rd_mask),
    .rd_asid_o(rd_asid), .rd_half0_o(rd_h0), .rd_half1_o(rd_h1)
  );

  function automatic logic [HW-1:0] enc(logic [PW-1:0] p, logic [2:0] c, logic d, logic v, logic g);
    return {p, c, d, v, g};
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [VW-1:0] m, input logic [VW-1:0] v,
                          input logic [AW-1:0] a, input logic g,
                          input logic [PW-1:0] p0, input logic [2:0] c0, input logic d0, input logic v0,
                          input logic [PW-1:0] p1, input logic [2:0] c1, input logic d1, input logic v1);
    @(negedge clk);
    wr_en = 1; wr_idx = PT'(idx); wr_mask = m; wr_vpn = v; wr_asid = a; wr_g = g;
    wr_pfn0 = p0; wr_c0 = c0; wr_d0 = d0; wr_v0 = v0;
    wr_pfn1 = p1; wr_c1 = c1; wr_d1 = d1; wr_v1 = v1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_lookup(input logic [VW-1:0] v, input logic [AW-1:0] a,
                           input logic exp_hit, input int exp_idx, input string tag);
    @(negedge clk);
    lkp_valid = 1; lkp_vpn = v; lkp_asid = a;
    @(negedge clk);
    lkp_valid = 0;
    chk(res_valid == 1'b1, {tag, " valid"}, res_valid, 1);
    chk(res_hit == exp_hit, {tag, " hit"}, res_hit, exp_hit);
    if (exp_hit) begin
      chk(res_idx == IW'(exp_idx), {tag, " idx"}, res_idx, exp_idx);
      chk(res_probe == PT'(exp_idx), {tag, " probe"}, res_probe, exp_idx);
    end else begin
      chk(res_probe == '1, {tag, " probe -1"}, res_probe, 4'hF);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(next_idx == 0, "R12 ptr", next_idx, 0);
    chk(res_hit == 0 && res_valid == 0, "R12 res", {res_valid, res_hit}, 0);
    rd_idx = 0; #1;
    chk(rd_ok && rd_h0 == '0 && rd_h1 == '0, "R12 slot empty", rd_h0, 0);
    do_lookup(12'h000, 4'h0, 0, 0, "R5 empty slot no hit");
  endtask

  task automatic t_encode;
    do_write(2, 12'h000, 12'h222, 4'h9, 1'b1, 10'h2A5, 3'd5, 1'b1, 1'b0, 10'h13C, 3'd2, 1'b0, 1'b1);
    rd_idx = 2; #1;
    chk(rd_h0 == enc(10'h2A5, 3'd5, 1, 0, 1), "R6 half0", rd_h0, enc(10'h2A5, 3'd5, 1, 0, 1));
    chk(rd_h1 == enc(10'h13C, 3'd2, 0, 1, 1), "R6 half1", rd_h1, enc(10'h13C, 3'd2, 0, 1, 1));
    chk(rd_vpn == 12'h222 && rd_asid == 4'h9, "R11 read fields", rd_vpn, 12'h222);
    do_lookup(12'h222, 4'h1, 1, 2, "R6 lookup");
    chk(res_h0 == enc(10'h2A5, 3'd5, 1, 0, 1), "R6 res half0", res_h0, enc(10'h2A5, 3'd5, 1, 0, 1));
  endtask

  task automatic t_mask;
    do_write(0, 12'h00F, 12'h120, 4'h3, 1'b0, 10'h011, 3'd1, 1'b0, 1'b1, 10'h0, 3'd0, 1'b0, 1'b0);
    do_lookup(12'h12A, 4'h3, 1, 0, "R1 masked bits ignored");
    chk(res_mask == 12'h00F, "R1 res mask", res_mask, 12'h00F);
    do_lookup(12'h13A, 4'h3, 0, 0, "R1 unmasked bit differs");
  endtask

  task automatic t_asid;
    do_lookup(12'h120, 4'h5, 0, 0, "R2 asid mismatch");
    do_write(1, 12'h000, 12'h300, 4'h7, 1'b1, 10'h030, 3'd0, 1'b0, 1'b1, 10'h0, 3'd0, 1'b0, 1'b0);
    do_lookup(12'h300, 4'h2, 1, 1, "R2 global any asid");
    chk(res_asid == 4'h7, "R2 res asid", res_asid, 4'h7);
  endtask

  task automatic t_prio;
    do_write(4, 12'h000, 12'h555, 4'h1, 1'b0, 10'h0, 3'd0, 1'b0, 1'b0, 10'h044, 3'd0, 1'b0, 1'b1);
    do_write(3, 12'h000, 12'h555, 4'h1, 1'b0, 10'h0, 3'd0, 1'b0, 1'b0, 10'h033, 3'd0, 1'b0, 1'b1);
    do_lookup(12'h555, 4'h1, 1, 3, "R3 lowest wins");
    chk(res_h1 == enc(10'h033, 0, 0, 1, 0), "R3 winner data", res_h1, enc(10'h033, 0, 0, 1, 0));
    do_write(3, 12'h000, 12'h555, 4'h1, 1'b0, 10'h0, 3'd0, 1'b0, 1'b0, 10'h033, 3'd0, 1'b0, 1'b0);
    do_lookup(12'h555, 4'h1, 1, 4, "R5 both invalid skipped");
  endtask

  task automatic t_overwrite;
    do_write(4, 12'h000, 12'h666, 4'h1, 1'b0, 10'h066, 3'd0, 1'b0, 1'b1, 10'h0, 3'd0, 1'b0, 1'b0);
    do_lookup(12'h555, 4'h1, 0, 0, "R8 old vpn gone");
    do_lookup(12'h666, 4'h1, 1, 4, "R8 new vpn");
  endtask

  task automatic t_reject;
    rd_idx = 5; #1;
    chk(rd_ok && rd_h0 == '0, "R7 slot5 before", rd_h0, 0);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd6; wr_vpn = 12'h777; wr_v0 = 1; wr_g = 1;
    @(negedge clk);
    wr_en = 0;
    chk(wr_reject == 1'b1, "R7 reject idx6", wr_reject, 1);
    @(negedge clk);
    chk(wr_reject == 1'b0, "R7 reject one cycle", wr_reject, 0);
    do_write(15, 12'h000, 12'h777, 4'h0, 1'b1, 10'h1, 3'd0, 1'b0, 1'b1, 10'h0, 3'd0, 1'b0, 1'b0);
    do_lookup(12'h777, 4'h0, 0, 0, "R7 table unchanged");
    rd_idx = 5; #1;
    chk(rd_h0 == '0, "R7 slot5 after", rd_h0, 0);
    rd_idx = 6; #1;
    chk(!rd_ok && rd_vpn == '0, "R11 rd out of range", rd_ok, 0);
  endtask

  task automatic t_advance;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk); adv = 1;
      @(negedge clk); adv = 0;
      chk(next_idx == IW'(k % SIZE), "R10 ptr step", next_idx, k % SIZE);
    end
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1; adv = 1;
    wr_en = 1; wr_idx = 4'd5; wr_vpn = 12'h5A5; wr_v0 = 1; wr_g = 1;
    @(negedge clk); flush = 0; adv = 0; wr_en = 0;
    chk(next_idx == 0, "R9 ptr cleared", next_idx, 0);
    do_lookup(12'h300, 4'h2, 0, 0, "R9 global gone");
    do_lookup(12'h5A5, 4'h0, 0, 0, "R9 flush beats write");
    for (int i = 0; i < SIZE; i++) begin
      rd_idx = PT'(i); #1;
      chk(rd_h0 == '0 && rd_h1 == '0 && rd_vpn == '0, "R9 slot zero", rd_h0, 0);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_encode;
        t_mask;
        t_asid;
        t_prio;
        t_overwrite;
        t_reject;
        t_advance;
        t_flush;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule